// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block vets every memory access a processor core issues against a single bank of eight programmable protection regions. Each region covers a naturally aligned, power-of-two sized window of the 32-bit address space. It carries a two-bit permission code and a cacheable and a bufferable attribute. An access supplies an address, a privileged/user indication and a read/write indication. One clock later the block reports whether the access must be aborted, and which cache and buffer attributes apply.

Regions may overlap. When more than one enabled region covers an address, the region with the highest number wins. A large low-numbered region can therefore serve as a background, with smaller high-numbered regions carving exceptions out of it. Software loads regions, permissions, attribute masks and a global enable through a plain register-write port. While the global enable is clear, the block lets everything through as uncached and unbuffered.

Top module: `region_prot_checker`

## Requirements
- R1: A response appears exactly one cycle after an access is presented: `rsp_valid` is high in the cycle after `acc_valid`. While `rsp_valid` is low, `rsp_abort`, `rsp_cache` and `rsp_buffer` are low.
- R2: Config addresses 0 to 7 load region words. In a region word, bits [31:12] hold the base, bits [5:1] hold the size code N and bit 0 enables the region. Bits [11:6] are ignored, and a region whose bit 0 is clear never matches.
- R3: A region spans 2^(N+1) bytes. Codes below 11 are treated as 11 (4 KB), and N=31 covers the whole 4 GB space.
- R4: Base bits below the region size are ignored, so the region is always aligned to its size.
- R5: With the unit enabled, an access matching no enabled region aborts, with cache and buffer low.
- R6: Among several matching enabled regions, the highest-numbered one alone supplies permission and attributes, whatever the privilege.
- R7: Config address 8 holds the permission codes, with region i at bits [2i+1:2i]. The codes are: 00 means no access at all; 01 means privileged read/write only; 10 means privileged read/write and user read-only; 11 means read/write for both. A violating access aborts.
- R8: Config address 11, bit 0, is the global enable. While it is clear, every access reports abort, cache and buffer all low.
- R9: Config address 9 is the cacheable mask and address 10 the bufferable mask, with bit i belonging to region i. The winning region's bits are reported, including on a permission abort.
- R10: A configuration write affects an access presented in the very next cycle.
- R11: After reset all regions, masks, permissions and the global enable are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select (0-7 regions, 8 permissions, 9 cache mask, 10 buffer mask, 11 control) |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_priv | input | 1 | 1 = privileged, 0 = user |
| acc_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_abort | output | 1 | Access must be aborted |
| rsp_cache | output | 1 | Access is cacheable |
| rsp_buffer | output | 1 | Access is bufferable |

## Verification
The bench stacks a 4 GB background region, a 256 KB region and a size code below the legal minimum at one base. The winner then changes with the address. A design that resolves priority toward the lowest index, or that lets an undersized code shrink below 4 KB, reports the wrong region's permission. Accesses just past a region's last byte, a base carrying stray low bits, and junk in the ignored field catch a mask that is one bit off. A user write to a read-only region and the "no access" code catch a permission decoder that merges the privilege modes. Accesses placed directly after a configuration write, and after disabling the unit, expose a design that adds a cycle of configuration latency or forgets to force the attributes low.

// File: rtl/rprot_pkg.sv
package rprot_pkg;

    localparam int AW       = 32;
    localparam int PGB      = 12;   // lowest base bit (4 KB granule)
    localparam int SZW      = 5;    // width of the size code
    localparam int MIN_CODE = 11;   // smallest legal size code

    typedef enum logic [1:0] {
        AP_NONE  = 2'b00,
        AP_PRIV  = 2'b01,
        AP_UREAD = 2'b10,
        AP_FULL  = 2'b11
    } perm_e;

    typedef struct packed {
        logic [AW-1:PGB] base;
        logic [SZW-1:0]  size;
        logic            en;
    } region_t;

    typedef struct packed {
        logic valid;
        logic abort;
        logic cache;
        logic buffer;
    } rsp_t;

    // Bits of the base that take part in the compare for a given size code
    function automatic logic [AW-1:PGB] keep_mask(input logic [SZW-1:0] code);
        int eff;
        logic [AW-1:PGB] m;
        eff = (int'(code) < MIN_CODE) ? MIN_CODE : int'(code);
        for (int b = PGB; b < AW; b++) begin
            m[b] = (b > eff);
        end
        return m;
    endfunction

endpackage

// File: rtl/rprot_cfg_regs.sv
module rprot_cfg_regs
    import rprot_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IDXW = $clog2(NREG),
    localparam int CAW  = $clog2(NREG + 4)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CAW-1:0]         cfg_addr,
    input  logic [AW-1:0]          cfg_wdata,
    output region_t [NREG-1:0]     rgn_o,
    output logic [2*NREG-1:0]      perm_o,
    output logic [NREG-1:0]        cache_mask_o,
    output logic [NREG-1:0]        buf_mask_o,
    output logic                   glb_en_o
);

    localparam int ADDR_PERM  = NREG;
    localparam int ADDR_CACHE = NREG + 1;
    localparam int ADDR_BUF   = NREG + 2;
    localparam int ADDR_CTRL  = NREG + 3;

    typedef struct packed {
        region_t [NREG-1:0] rgn;
        logic [2*NREG-1:0]  perm;
        logic [NREG-1:0]    cmask;
        logic [NREG-1:0]    bmask;
        logic               en;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (int'(cfg_addr) < NREG) begin
                st_d.rgn[cfg_addr[IDXW-1:0]] = '{
                    base: cfg_wdata[AW-1:PGB],
                    size: cfg_wdata[SZW:1],
                    en:   cfg_wdata[0]
                };
            end else if (int'(cfg_addr) == ADDR_PERM) begin
                st_d.perm = cfg_wdata[2*NREG-1:0];
            end else if (int'(cfg_addr) == ADDR_CACHE) begin
                st_d.cmask = cfg_wdata[NREG-1:0];
            end else if (int'(cfg_addr) == ADDR_BUF) begin
                st_d.bmask = cfg_wdata[NREG-1:0];
            end else if (int'(cfg_addr) == ADDR_CTRL) begin
                st_d.en = cfg_wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rgn_o        = st_q.rgn;
    assign perm_o       = st_q.perm;
    assign cache_mask_o = st_q.cmask;
    assign buf_mask_o   = st_q.bmask;
    assign glb_en_o     = st_q.en;

    // R10
    ctrl_write_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_addr) == ADDR_CTRL) |=> (glb_en_o == $past(cfg_wdata[0])));

    // R10
    perm_write_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_addr) == ADDR_PERM) |=> (perm_o == $past(cfg_wdata[2*NREG-1:0])));

endmodule

// File: rtl/rprot_region_match.sv
module rprot_region_match
    import rprot_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic [AW-1:0]      addr_i,
    input  region_t [NREG-1:0] rgn_i,
    output logic [NREG-1:0]    hit_o
);

    for (genvar g = 0; g < NREG; g++) begin : g_rgn
        logic [AW-1:PGB] keep;
        logic [AW-1:PGB] diff;
        always_comb begin
            keep     = keep_mask(rgn_i[g].size);
            diff     = (addr_i[AW-1:PGB] ^ rgn_i[g].base) & keep;
            hit_o[g] = rgn_i[g].en && (diff == '0);
        end
    end

endmodule

// File: rtl/rprot_resolve.sv
module rprot_resolve
    import rprot_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NREG-1:0]     hit_i,
    input  logic [2*NREG-1:0]   perm_i,
    input  logic [NREG-1:0]     cache_mask_i,
    input  logic [NREG-1:0]     buf_mask_i,
    input  logic                priv_i,
    input  logic                write_i,
    output logic                abort_o,
    output logic                cache_o,
    output logic                buffer_o
);

    logic            any_hit;
    logic [IDXW-1:0] win_idx;
    perm_e           win_ap;
    logic            allowed;

    // Later (higher-numbered) hits override earlier ones
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit_i[i]) begin
                any_hit = 1'b1;
                win_idx = i[IDXW-1:0];
            end
        end
    end

    always_comb begin
        win_ap = perm_e'(perm_i[2*win_idx +: 2]);
        unique case (win_ap)
            AP_NONE:  allowed = 1'b0;
            AP_PRIV:  allowed = priv_i;
            AP_UREAD: allowed = priv_i || !write_i;
            AP_FULL:  allowed = 1'b1;
            default:  allowed = 1'b0;
        endcase
        abort_o  = !any_hit || !allowed;
        cache_o  = any_hit && cache_mask_i[win_idx];
        buffer_o = any_hit && buf_mask_i[win_idx];
    end

    // R6
    highest_hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ((hit_i >> win_idx) == NREG'(1)));

    // R7
    user_write_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_hit && !priv_i && write_i && win_ap != AP_FULL) |-> abort_o);

    // R5
    miss_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i == '0) |-> (abort_o && !cache_o && !buffer_o));

endmodule

// File: rtl/region_prot_checker.sv
module region_prot_checker
    import rprot_pkg::*;
#(
    parameter int NREG = 8,
    localparam int CAW = $clog2(NREG + 4)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CAW-1:0] cfg_addr,
    input  logic [31:0]    cfg_wdata,
    input  logic           acc_valid,
    input  logic [31:0]    acc_addr,
    input  logic           acc_priv,
    input  logic           acc_write,
    output logic           rsp_valid,
    output logic           rsp_abort,
    output logic           rsp_cache,
    output logic           rsp_buffer
);

    region_t [NREG-1:0] rgn;
    logic [2*NREG-1:0]  perm;
    logic [NREG-1:0]    cmask;
    logic [NREG-1:0]    bmask;
    logic               glb_en;
    logic [NREG-1:0]    hit;
    logic               res_abort;
    logic               res_cache;
    logic               res_buffer;

    rprot_cfg_regs #(.NREG(NREG)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .rgn_o        (rgn),
        .perm_o       (perm),
        .cache_mask_o (cmask),
        .buf_mask_o   (bmask),
        .glb_en_o     (glb_en)
    );

    rprot_region_match #(.NREG(NREG)) u_match (
        .addr_i (acc_addr),
        .rgn_i  (rgn),
        .hit_o  (hit)
    );

    rprot_resolve #(.NREG(NREG)) u_resolve (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit),
        .perm_i       (perm),
        .cache_mask_i (cmask),
        .buf_mask_i   (bmask),
        .priv_i       (acc_priv),
        .write_i      (acc_write),
        .abort_o      (res_abort),
        .cache_o      (res_cache),
        .buffer_o     (res_buffer)
    );

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = acc_valid;
        if (acc_valid && glb_en) begin
            rsp_d.abort  = res_abort;
            rsp_d.cache  = res_cache;
            rsp_d.buffer = res_buffer;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_abort  = rsp_q.abort;
    assign rsp_cache  = rsp_q.cache;
    assign rsp_buffer = rsp_q.buffer;

    // R1
    one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_abort && !rsp_cache && !rsp_buffer));

    // R8
    disabled_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !glb_en) |=> (!rsp_abort && !rsp_cache && !rsp_buffer));

endmodule

// File: tb/tb_region_prot_checker.sv
module tb_region_prot_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_priv = 1'b0;
    logic        acc_write = 1'b0;
    logic        rsp_valid, rsp_abort, rsp_cache, rsp_buffer;

    always #2.5 clk = ~clk;   // 200 MHz

    region_prot_checker dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_priv(acc_priv), .acc_write(acc_write),
        .rsp_valid(rsp_valid), .rsp_abort(rsp_abort),
        .rsp_cache(rsp_cache), .rsp_buffer(rsp_buffer)
    );

    typedef struct {
        logic [2:0] exp;   // {abort, cache, buffer}
        string      tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Independent reference state
    logic [31:0] m_rgn [8];
    logic [15:0] m_perm = '0;
    logic [7:0]  m_cm = '0;
    logic [7:0]  m_bm = '0;
    logic        m_en = 1'b0;

    initial for (int i = 0; i < 8; i++) m_rgn[i] = '0;

    function automatic logic [2:0] model(input logic [31:0] a, input logic pr, input logic wr);
        int win;
        int n;
        logic [63:0] sz;
        logic [63:0] lo;
        logic [1:0] ap;
        logic ok;
        if (!m_en) return 3'b000;
        win = -1;
        for (int i = 0; i < 8; i++) begin
            if (m_rgn[i][0]) begin
                n  = int'(m_rgn[i][5:1]);
                if (n < 11) n = 11;
                sz = 64'd1 << (n + 1);
                lo = {32'd0, m_rgn[i][31:12], 12'd0} & ~(sz - 64'd1);
                if (({32'd0, a} & ~(sz - 64'd1)) == lo) win = i;
            end
        end
        if (win < 0) return 3'b100;
        ap = m_perm[2*win +: 2];
        case (ap)
            2'b00:   ok = 1'b0;
            2'b01:   ok = pr;
            2'b10:   ok = pr || !wr;
            default: ok = 1'b1;
        endcase
        return {!ok, m_cm[win], m_bm[win]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Tasks start right after a negedge and return at the next one
    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a < 8) m_rgn[a[2:0]] = d;
        else if (a == 8) m_perm = d[15:0];
        else if (a == 9) m_cm = d[7:0];
        else if (a == 10) m_bm = d[7:0];
        else if (a == 11) m_en = d[0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_acc(input string tag, input logic [31:0] a, input logic pr, input logic wr);
        item_t it;
        acc_valid = 1'b1; acc_addr = a; acc_priv = pr; acc_write = wr;
        it.exp = model(a, pr, wr);
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R1 actual=unexpected response expected=none");
            end else begin
                item_t it;
                it = q.pop_front();
                check(it.tag, {29'd0, rsp_abort, rsp_cache, rsp_buffer}, {29'd0, it.exp});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs quiet during reset
        check("R11 reset outputs", {28'd0, rsp_valid, rsp_abort, rsp_cache, rsp_buffer}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: cleared state lets accesses pass uncached
        do_acc("R11 post-reset access", 32'h0000_1000, 1'b0, 1'b1);
        // R1: idle cycle gives no response
        check("R1 idle response", {31'd0, rsp_valid}, 32'd1);
        @(negedge clk);
        check("R1 no response when idle", {28'd0, rsp_valid, rsp_abort, rsp_cache, rsp_buffer}, 32'd0);

        // R10/R5: enable with no regions, access the next cycle -> abort
        cfg_write(4'd11, 32'h1);
        do_acc("R10 R5 miss after enable", 32'h1234_5678, 1'b1, 1'b0);

        // Background 4 GB region 0, full access, cacheable
        cfg_write(4'd8, 32'h0000_0483);
        cfg_write(4'd9, 32'h0000_0001);
        cfg_write(4'd10, 32'h0000_0028);
        cfg_write(4'd0, 32'h0000_003F);
        do_acc("R3 R9 whole space", 32'h1234_5678, 1'b0, 1'b1);
        do_acc("R3 top address", 32'hFFFF_FFFC, 1'b0, 1'b0);

        // Region 3: 256 KB at 0x300000, user read-only, bufferable
        cfg_write(4'd3, 32'h0030_0023);
        do_acc("R6 R9 overlay user read", 32'h0033_FFFC, 1'b0, 1'b0);
        do_acc("R7 user write read-only", 32'h0033_FFFC, 1'b0, 1'b1);
        do_acc("R7 priv write", 32'h0030_0000, 1'b1, 1'b1);
        do_acc("R3 past end", 32'h0034_0000, 1'b0, 1'b1);
        do_acc("R3 before start", 32'h002F_FFFC, 1'b0, 1'b1);

        // R4/R2: base with stray low bits and junk in ignored field
        cfg_write(4'd3, 32'h0030_5FE3);
        do_acc("R4 R2 stray base bits", 32'h0030_0010, 1'b0, 1'b1);
        do_acc("R4 R2 stray base read", 32'h0030_0010, 1'b0, 1'b0);

        // Region 5: undersized code -> 4 KB, privileged only
        cfg_write(4'd5, 32'h0030_000B);
        do_acc("R3 R7 small code user", 32'h0030_0800, 1'b0, 1'b0);
        do_acc("R3 small code beyond 4KB", 32'h0030_1000, 1'b0, 1'b0);
        do_acc("R7 R9 priv in priv-only", 32'h0030_0FFC, 1'b1, 1'b1);

        // Region 7: disabled, then enabled with no-access code
        cfg_write(4'd7, 32'h0030_0016);
        do_acc("R2 disabled region ignored", 32'h0030_0100, 1'b1, 1'b0);
        cfg_write(4'd7, 32'h0030_0017);
        do_acc("R7 R6 no-access code", 32'h0030_0100, 1'b1, 1'b0);

        // R5: drop background, miss aborts uncached
        cfg_write(4'd0, 32'h0000_003E);
        do_acc("R5 miss after background off", 32'h8000_0000, 1'b1, 1'b0);

        // R8: unit disabled -> pass everything
        cfg_write(4'd11, 32'h0);
        do_acc("R8 disabled no-access region", 32'h0030_0100, 1'b0, 1'b1);
        do_acc("R8 disabled miss", 32'h8000_0000, 1'b0, 1'b0);

        idle(3);
        check("R1 all responses seen", q.size(), 32'd0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule